// File: doc/BRIEF.md
# Four-Lane 7:1 Serializer with Forwarded Frame Clock

This block turns a wide parallel word into four narrow serial lanes, with a fifth lane for the clock. It runs on one bit-rate clock. That clock is seven times the word rate and is assumed phase-locked by logic outside the block. An internal slot counter splits the bit clock into word periods of seven slots. The block captures the 28-bit input once per word period, at the close of slot six. Each 7-bit group of the word then goes out on its own lane, lowest bit first. The fifth lane repeats a fixed 7-slot pattern, so a receiver can find where each word starts.

Each lane gives a logic-level bit, and one shared output enable stands in for the tri-state control of the differential drivers. A synchronous reset and an active-low powerdown input both clear the block. They hold the enable low and force every lane output to zero. When both are released, the block waits a parameterised number of word periods before it raises the enable, which leaves time for an external PLL to settle. Frames then follow back to back with no idle slot between them.

Top module: `lvds7_serializer`

## Requirements
- R1: The block samples `par_word` only at the bit-clock edge that ends slot 6 of each word period. A change of `par_word` during slots 0 to 5 does not appear on any lane.
- R2: Lane k (`ser_data[k]`) carries `par_word[7k+6:7k]`, one bit per bit-clock cycle, lowest-numbered bit first.
- R3: Each word occupies exactly seven consecutive bit-clock cycles on every lane. Successive captured words are sent with no idle cycle between them.
- R4: In every frame, `ser_fclk` sends the sequence 1,1,0,0,0,1,1 in step with bit 0 through bit 6 of the data lanes. Its low-to-high transition therefore always falls between bit 4 and bit 5.
- R5: While `rst` is high at a rising edge, that edge clears `ser_oe`, `ser_data` and `ser_fclk` to zero.
- R6: While `pd_n` is low, from the first edge that sees it low, `ser_oe` stays low and every lane output stays zero.
- R7: After `rst` and `pd_n` are both released, `ser_oe` first reads high after the (7*LOCK_WORDS+1)-th rising edge. That edge also presents bit 0 of the LOCK_WORDS-th word captured after release.
- R8: Once high, `ser_oe` stays high for as long as `rst` stays low and `pd_n` stays high.
- R9: Whenever `ser_oe` is low, `ser_data` is all zero and `ser_fclk` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, seven cycles per word |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Active-low powerdown |
| par_word | input | LANES*RATIO (28) | Parallel word, sampled at the end of slot 6 |
| ser_data | output | LANES (4) | Serial data lane bits |
| ser_fclk | output | 1 | Forwarded frame-clock lane bit |
| ser_oe | output | 1 | Output enable, low means the lanes are tri-stated |

## Verification
Frames of all zeros and all ones show that every lane carries data and that no lane is stuck. A single one walked across all 28 positions shows whether the lane assignment and the bit order within each lane are correct. An alternating pattern separates neighbouring bits, and a scrambled sequence separates successive words. That sequence also catches a gap or a duplicated frame. In the scrambled frames the input is disturbed in the middle of each word period, so a capture at the wrong slot shows up. Each release is followed by an exact count of cycles to the rise of the enable, and then a powerdown and a reset in mid-stream check that the outputs go quiet and the lock wait starts again.

// File: rtl/lvds7_pkg.sv
package lvds7_pkg;
  // Frame-clock lane pattern, bit 0 sent first: 1,1,0,0,0,1,1
  localparam logic [6:0] FCLK_DEF = 7'b1100011;
endpackage

// File: rtl/lvds7_phase_gen.sv
module lvds7_phase_gen #(
  parameter int RATIO = 7,
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic          clk,
  input  logic          clr,
  output logic [PW-1:0] phase,
  output logic          load
);
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  always_ff @(posedge clk) begin
    if (clr)               phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                   phase <= phase + 1'b1;
  end

  assign load = !clr && (phase == LAST);
endmodule

// File: rtl/lvds7_lock_timer.sv
module lvds7_lock_timer #(
  parameter int LOCK_WORDS = 4,
  localparam int CW = $clog2(LOCK_WORDS) + 1
) (
  input  logic clk,
  input  logic clr,
  input  logic load,
  output logic locked
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (load && !locked) begin
      if (cnt == CW'(LOCK_WORDS - 1)) locked <= 1'b1;
      else                            cnt    <= cnt + 1'b1;
    end
  end

  // R7: the enable source only turns on at a word boundary
  a_r7_lock_at_boundary: assert property (@(posedge clk) disable iff (clr)
    $rose(locked) |-> $past(load));
endmodule

// File: rtl/lvds7_lane_shifter.sv
module lvds7_lane_shifter #(
  parameter int RATIO = 7
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic [RATIO-1:0] load_val,
  output logic             sout
);
  logic [RATIO-1:0] sr;

  always_ff @(posedge clk) begin
    if (clr)       sr <= '0;
    else if (load) sr <= load_val;
    else           sr <= {1'b0, sr[RATIO-1:1]};
  end

  assign sout = sr[0];
endmodule

// File: rtl/lvds7_serializer.sv
module lvds7_serializer
  import lvds7_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int RATIO      = 7,
  parameter int LOCK_WORDS = 4,
  parameter logic [RATIO-1:0] FCLK_PATTERN = RATIO'(FCLK_DEF)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pd_n,
  input  logic [LANES*RATIO-1:0] par_word,
  output logic [LANES-1:0]       ser_data,
  output logic                   ser_fclk,
  output logic                   ser_oe
);
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic             clr;
  logic [PW-1:0]    phase;
  logic             load;
  logic             locked;
  logic [LANES-1:0] lane_bit;
  logic             fclk_bit;

  assign clr = rst || !pd_n;

  lvds7_phase_gen #(.RATIO(RATIO)) u_phase (
    .clk(clk), .clr(clr), .phase(phase), .load(load)
  );

  lvds7_lock_timer #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
    .clk(clk), .clr(clr), .load(load), .locked(locked)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lvds7_lane_shifter #(.RATIO(RATIO)) u_sh (
      .clk(clk), .clr(clr), .load(load),
      .load_val(par_word[k*RATIO +: RATIO]),
      .sout(lane_bit[k])
    );
  end

  lvds7_lane_shifter #(.RATIO(RATIO)) u_fclk (
    .clk(clk), .clr(clr), .load(load),
    .load_val(FCLK_PATTERN),
    .sout(fclk_bit)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      ser_oe   <= 1'b0;
      ser_data <= '0;
      ser_fclk <= 1'b0;
    end else begin
      ser_oe   <= locked;
      ser_data <= locked ? lane_bit : '0;
      ser_fclk <= locked && fclk_bit;
    end
  end

  // R9: an idle link shows no activity
  a_r9_quiet_when_off: assert property (@(posedge clk)
    !ser_oe |-> (ser_data == '0) && !ser_fclk);

  // R6: powerdown turns the enable off at the next edge
  a_r6_pd_disables: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> !ser_oe);

  // R8: no dropout of the enable while running
  a_r8_oe_holds: assert property (@(posedge clk) disable iff (clr)
    ser_oe |=> ser_oe);

  // R4: frame clock high on bit 0, low on bit 2
  a_r4_fclk_high_bit0: assert property (@(posedge clk) disable iff (clr)
    ser_oe && (phase == PW'(1)) |-> ser_fclk);
  a_r4_fclk_low_bit2: assert property (@(posedge clk) disable iff (clr)
    ser_oe && (phase == PW'(3)) |-> !ser_fclk);
endmodule

// File: tb/lvds7_serializer_test.sv
`timescale 1ns/1ps
module lvds7_serializer_test;
  localparam int LANES = 4;
  localparam int RATIO = 7;
  localparam int LOCKW = 3;
  localparam int DW    = LANES*RATIO;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pd_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [LANES-1:0] ser_data;
  logic          ser_fclk;
  logic          ser_oe;

  int checks = 0;
  int errors = 0;
  int bphase = 0;
  int loads  = 0;
  int fidx   = 0;
  int mode   = 0;
  int frames = 0;
  int idx;
  bit noisy  = 1'b0;
  logic [DW-1:0] wsave = '0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] acc = '0;
  logic [DW-1:0] expw;
  logic [6:0]    cacc = '0;

  always #10 clk = ~clk;

  lvds7_serializer #(.LANES(LANES), .RATIO(RATIO), .LOCK_WORDS(LOCKW)) uut (
    .clk(clk), .rst(rst), .pd_n(pd_n), .par_word(din),
    .ser_data(ser_data), .ser_fclk(ser_fclk), .ser_oe(ser_oe)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Slot model from R1/R3: slot 6 edge captures, then slot 0 follows
  always @(posedge clk) begin
    if (rst || !pd_n) begin
      bphase <= 0;
      loads  <= 0;
    end else begin
      bphase <= (bphase == 6) ? 0 : bphase + 1;
      if (bphase == 6) loads <= loads + 1;
    end
  end

  function automatic logic [DW-1:0] gen(input int n);
    case (mode)
      0: gen = '0;
      1: gen = '1;
      2: gen = DW'(1) << (n % DW);
      3: gen = (n % 2 == 0) ? 28'h5555555 : 28'hAAAAAAA;
      default: gen = DW'(n * 32'h9E3779B1 ^ 32'h1234567);
    endcase
  endfunction

  // Driver: new word at slot 0, disturbance mid-frame when noisy (R1)
  initial begin
    forever begin
      @(posedge clk); #1;
      if (bphase == 0) begin
        wsave = gen(fidx);
        fidx++;
        din = wsave;
        if (!rst && pd_n && (loads + 1 >= LOCKW)) q.push_back(wsave);
      end else if (noisy && bphase == 1) begin
        din = ~wsave;
      end else if (noisy && bphase == 3) begin
        din = wsave ^ 28'h0F0F0F0;
      end else if (noisy && bphase == 6) begin
        din = wsave;
      end
    end
  end

  // Monitor: rebuild frames from the lanes and compare with the queue
  always @(negedge clk) begin
    if (!ser_oe) begin
      chk((ser_data == '0) && !ser_fclk, "R9 quiet outputs",
          {27'd0, ser_fclk, ser_data}, 32'd0);
    end else if (!rst && pd_n) begin
      idx = (bphase + 6) % 7;
      for (int k = 0; k < LANES; k++) acc[k*RATIO + idx] = ser_data[k];
      cacc[idx] = ser_fclk;
      if (idx == 6) begin
        frames++;
        chk(cacc == 7'b1100011, "R4 frame clock pattern", {25'd0, cacc}, 32'h63);
        if (q.size() == 0) begin
          chk(1'b0, "R3 unexpected frame", acc, 32'd0);
        end else begin
          expw = q.pop_front();
          chk(acc == expw, "R1 R2 R3 frame word", acc, expw);
        end
      end
    end
  end

  task automatic measure_lock(input string tag);
    int n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!ser_oe && n < 500);
    chk(n == 7*LOCKW + 1, tag, n, 7*LOCKW + 1);
  endtask

  task automatic frames_wait(input int nf);
    repeat (nf * 7) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!ser_oe && ser_data == '0 && !ser_fclk, "R5 reset state",
        {26'd0, ser_oe, ser_fclk, ser_data}, 32'd0);
    rst = 1'b0;
    measure_lock("R7 lock wait after reset");

    mode = 0; frames_wait(4);
    mode = 1; frames_wait(4);
    mode = 2; frames_wait(30);
    mode = 3; frames_wait(6);
    mode = 4; noisy = 1'b1; frames_wait(12);
    chk(ser_oe, "R8 enable held while running", {31'd0, ser_oe}, 32'd1);

    // Powerdown in mid-stream (R6)
    while (bphase != 3) begin @(posedge clk); #1; end
    pd_n = 1'b0;
    @(posedge clk); #1;
    q.delete();
    chk(!ser_oe, "R6 enable off after powerdown", {31'd0, ser_oe}, 32'd0);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      chk(!ser_oe && ser_data == '0 && !ser_fclk, "R6 held off in powerdown",
          {26'd0, ser_oe, ser_fclk, ser_data}, 32'd0);
    end
    pd_n = 1'b1;
    measure_lock("R7 lock wait after powerdown");
    noisy = 1'b0;
    frames_wait(8);

    // Reset in mid-stream (R5)
    while (bphase != 5) begin @(posedge clk); #1; end
    rst = 1'b1;
    @(posedge clk); #1;
    q.delete();
    chk(!ser_oe && ser_data == '0 && !ser_fclk, "R5 reset clears outputs",
        {26'd0, ser_oe, ser_fclk, ser_data}, 32'd0);
    @(posedge clk); #1;
    rst = 1'b0;
    measure_lock("R7 lock wait after second reset");
    mode = 2; frames_wait(10);
    chk(frames > 60, "R3 frame throughput", frames, 61);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule